// File: doc/BRIEF.md
# Minimal Single-Cycle RV32 Core (addi and ebreak)

This block is a very small RV32I-style processor core that finishes one instruction in every clock cycle. It holds a program counter and a 32-entry general-purpose register file. Instruction memory sits outside the core. The core drives its current program counter out on a port, and the matching 32-bit instruction word comes back on an input port in the same cycle.

The core understands two instructions. The first is the add-immediate. It adds a sign-extended 12-bit constant to a source register and writes the sum to a destination register. The second is the breakpoint word. It raises a halt output, after which the core freezes until it is reset. Every other word is treated as a no-op: the core only advances the program counter and flags the word as unrecognised. The core has no jump or branch, so the program counter only steps forward by one instruction.

A second, independent read port on the register file lets a test environment inspect any register at any time.

Top module: `mini_rv_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter is loaded with 0x80000000. While `rst` is high, `halt_o` and `illegal_o` stay low and no register is written.
- R2: While the core is running, `pc_o` increases by exactly 4 at every rising edge. This holds for add-immediate words and for unrecognised words alike.
- R3: A word is an add-immediate when bits [6:0] are 0010011 and bits [14:12] are 000. The fields are rd in bits [11:7], rs1 in bits [19:15] and the immediate in bits [31:20]. At the next edge, register rd receives register rs1 plus the immediate sign-extended to 32 bits, modulo 2^32.
- R4: Register 0 always reads as zero. An add-immediate whose rd is 0 changes no register.
- R5: When the incoming word equals exactly 0x00100073, `halt_o` is high in that same cycle, combinationally.
- R6: Once a breakpoint word has been accepted, three things hold until the next reset, whatever word arrives on `instr_i`: `halt_o` stays high, `pc_o` stays at the address of the breakpoint, and no register changes.
- R7: Any other word raises `illegal_o` in the same cycle, writes no register and still advances the program counter. This includes opcode 0010011 with a nonzero bits [14:12].
- R8: `dbg_data_o` combinationally shows the register selected by `dbg_addr_i`, and it shows zero for address 0.
- R9: A reset applied after a halt clears the halt. Execution then restarts at 0x80000000, and register contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_o | output | 32 | Address of the instruction being executed |
| instr_i | input | 32 | Instruction word at `pc_o`, supplied in the same cycle |
| halt_o | output | 1 | Breakpoint reached; the core is frozen |
| illegal_o | output | 1 | The current word is neither add-immediate nor breakpoint |
| dbg_addr_i | input | 5 | Register index for the inspection port |
| dbg_data_o | output | 32 | Contents of the selected register |

## Verification
The bench goes after several corner cases, and each one exposes a specific kind of faulty design.

- Immediate extremes: it uses the largest positive and the most negative immediates and a chained negative result. A design that zero-extends the immediate or drops bit 11 stores a wrong register value.
- Writes to register 0: a design that lets register 0 be written reads back nonzero from address 0.
- Near-miss and unrecognised words: it feeds a word that matches the opcode but has a different bits [14:12], and an all-ones word. A design that matches only the opcode writes a register, and a design that stalls on unknown words leaves the program counter behind.
- Halt behaviour: after the halt it presents an add-immediate word. A design whose halt is not sticky, or that still steps or writes, moves the program counter or changes a register.
- Restart: it resets after the halt. A design that does not clear the halt stays frozen.

// File: rtl/mini_rv_pkg.sv
package mini_rv_pkg;

  localparam int unsigned XLEN       = 32;
  localparam int unsigned REG_AW     = 5;
  localparam int unsigned NUM_REGS   = 1 << REG_AW;
  localparam int unsigned INSN_BYTES = 4;

  localparam logic [6:0]      OPC_ARITH_IMM = 7'b0010011;
  localparam logic [2:0]      SUB_ADD       = 3'b000;
  localparam logic [XLEN-1:0] WORD_BREAK    = 32'h0010_0073;

  typedef enum logic [1:0] {
    KIND_ADDI  = 2'd0,
    KIND_BREAK = 2'd1,
    KIND_OTHER = 2'd2
  } insn_kind_e;

  typedef struct packed {
    insn_kind_e        kind;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rs1;
    logic [XLEN-1:0]   imm;
  } decoded_t;

endpackage

// File: rtl/mini_rv_fetch.sv
module mini_rv_fetch #(
  parameter int unsigned        AW        = 32,
  parameter logic [AW-1:0]      RESET_VEC = 32'h8000_0000,
  parameter int unsigned        STEP      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_i,
  output logic [AW-1:0] pc_o
);

  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_d;
  logic          pc_en;

  always_comb begin
    pc_en = !hold_i;
    pc_d  = pc_q + AW'(STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= RESET_VEC;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  assign pc_o = pc_q;

  p_reset_vec_r1: assert property (@(posedge clk) rst |=> (pc_q == RESET_VEC));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    !hold_i |=> (pc_q == $past(pc_q) + AW'(STEP)));

  p_pc_hold_r6: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> $stable(pc_q));

endmodule

// File: rtl/mini_rv_decode.sv
module mini_rv_decode
  import mini_rv_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  output decoded_t        dec_o
);

  logic is_arith_imm;
  logic is_add;

  always_comb begin
    is_arith_imm = (instr_i[6:0] == OPC_ARITH_IMM);
    is_add       = is_arith_imm && (instr_i[14:12] == SUB_ADD);

    dec_o.rd  = instr_i[11:7];
    dec_o.rs1 = instr_i[19:15];
    dec_o.imm = {{(XLEN-12){instr_i[31]}}, instr_i[31:20]};

    if (instr_i == WORD_BREAK) begin
      dec_o.kind = KIND_BREAK;
    end else if (is_add) begin
      dec_o.kind = KIND_ADDI;
    end else begin
      dec_o.kind = KIND_OTHER;
    end
  end

endmodule

// File: rtl/mini_rv_regfile.sv
module mini_rv_regfile #(
  parameter int unsigned DW    = 32,
  parameter int unsigned NREGS = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);

  logic [DW-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_a_o = (raddr_a_i == '0) ? '0 : mem[raddr_a_i];
    rdata_b_o = (raddr_b_i == '0) ? '0 : mem[raddr_b_i];
  end

  p_no_x0_write_r4: assert property (@(posedge clk)
    we_i |-> (waddr_i != '0));

  p_x0_reads_zero_r8: assert property (@(posedge clk)
    (raddr_b_i == '0) |-> (rdata_b_o == '0));

endmodule

// File: rtl/mini_rv_exec.sv
module mini_rv_exec
  import mini_rv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  decoded_t          dec_i,
  input  logic [XLEN-1:0]   rs1_val_i,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o,
  output logic              hold_o,
  output logic              halt_o,
  output logic              illegal_o
);

  logic halted_q;
  logic halted_d;
  logic halted_en;
  logic running;
  logic brk;

  always_comb begin
    running    = !rst && !halted_q;
    brk        = (dec_i.kind == KIND_BREAK);
    rf_waddr_o = dec_i.rd;
    rf_wdata_o = rs1_val_i + dec_i.imm;
    rf_we_o    = running && (dec_i.kind == KIND_ADDI) && (dec_i.rd != '0);
    hold_o     = halted_q || brk;
    halt_o     = !rst && (halted_q || brk);
    illegal_o  = running && (dec_i.kind == KIND_OTHER);
    halted_en  = running && brk;
    halted_d   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q <= 1'b0;
    end else if (halted_en) begin
      halted_q <= halted_d;
    end
  end

  p_frozen_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    halted_q |-> !rf_we_o);

  p_other_no_effect_r7: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (!rf_we_o && !halt_o));

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |-> (!halt_o && !illegal_o && !rf_we_o));

endmodule

// File: rtl/mini_rv_core.sv
module mini_rv_core
  import mini_rv_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VEC = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst,
  output logic [XLEN-1:0]   pc_o,
  input  logic [XLEN-1:0]   instr_i,
  output logic              halt_o,
  output logic              illegal_o,
  input  logic [REG_AW-1:0] dbg_addr_i,
  output logic [XLEN-1:0]   dbg_data_o
);

  decoded_t          dec;
  logic [XLEN-1:0]   rs1_val;
  logic              rf_we;
  logic [REG_AW-1:0] rf_waddr;
  logic [XLEN-1:0]   rf_wdata;
  logic              hold;

  mini_rv_fetch #(
    .AW        (XLEN),
    .RESET_VEC (RESET_VEC),
    .STEP      (INSN_BYTES)
  ) u_fetch (
    .clk    (clk),
    .rst    (rst),
    .hold_i (hold),
    .pc_o   (pc_o)
  );

  mini_rv_decode u_decode (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  mini_rv_regfile #(
    .DW    (XLEN),
    .NREGS (NUM_REGS)
  ) u_regs (
    .clk       (clk),
    .we_i      (rf_we),
    .waddr_i   (rf_waddr),
    .wdata_i   (rf_wdata),
    .raddr_a_i (dec.rs1),
    .rdata_a_o (rs1_val),
    .raddr_b_i (dbg_addr_i),
    .rdata_b_o (dbg_data_o)
  );

  mini_rv_exec u_exec (
    .clk        (clk),
    .rst        (rst),
    .dec_i      (dec),
    .rs1_val_i  (rs1_val),
    .rf_we_o    (rf_we),
    .rf_waddr_o (rf_waddr),
    .rf_wdata_o (rf_wdata),
    .hold_o     (hold),
    .halt_o     (halt_o),
    .illegal_o  (illegal_o)
  );

  p_halt_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    halt_o |=> halt_o);

  p_break_halts_r5: assert property (@(posedge clk) disable iff (rst)
    (instr_i == WORD_BREAK) |-> halt_o);

endmodule

// File: tb/mini_rv_core_tb_top.sv
`timescale 1ns/1ps
module mini_rv_core_tb_top;

  localparam logic [31:0] RV   = 32'h8000_0000;
  localparam logic [31:0] BRK  = 32'h0010_0073;
  localparam int          PLEN = 32;

  typedef struct {
    logic [31:0] pc;
    logic        halt;
    logic        ill;
    logic [4:0]  rreg;
    logic [31:0] rval;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc;
  logic [31:0] instr;
  logic        halt;
  logic        ill;
  logic [4:0]  dbg_addr = 5'd0;
  logic [31:0] dbg_data;
  logic        ovr_en = 1'b0;
  logic [31:0] ovr_word = 32'h0;
  logic [31:0] prog [PLEN];
  logic [31:0] model [32];
  logic [31:0] written;
  item_t       sb [$];
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  always_comb begin
    logic [31:0] off;
    off = (pc - RV) >> 2;
    if (ovr_en) instr = ovr_word;
    else if (off < PLEN) instr = prog[off[4:0]];
    else instr = 32'h0000_0013;
  end

  mini_rv_core dut_i (
    .clk        (clk),
    .rst        (rst),
    .pc_o       (pc),
    .instr_i    (instr),
    .halt_o     (halt),
    .illegal_o  (ill),
    .dbg_addr_i (dbg_addr),
    .dbg_data_o (dbg_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_addi(input int rd, input int rs1, input int imm);
    logic [11:0] i12;
    i12 = imm[11:0];
    return {i12, rs1[4:0], 3'b000, rd[4:0], 7'b0010011};
  endfunction

  // Driver: walks the program with a reference model and queues expected items.
  task automatic build_trace(input int nsteps);
    logic [31:0] pcm;
    logic        hlt;
    logic [4:0]  rreg;
    pcm = RV; hlt = 1'b0; rreg = 5'd0;
    for (int s = 0; s < nsteps; s++) begin
      item_t it;
      logic [31:0] w;
      w = prog[((pcm - RV) >> 2) & 32'h1f];
      it.pc = pcm; it.rreg = rreg; it.rval = model[rreg];
      it.halt = hlt || (w == BRK);
      it.ill  = !hlt && (w != BRK) && !(w[6:0] == 7'b0010011 && w[14:12] == 3'b000);
      sb.push_back(it);
      if (hlt) begin
        // frozen (R6)
      end else if (w == BRK) begin
        hlt = 1'b1;
      end else if (w[6:0] == 7'b0010011 && w[14:12] == 3'b000) begin
        if (w[11:7] != 5'd0)
          model[w[11:7]] = model[w[19:15]] + {{20{w[31]}}, w[31:20]};
        written[w[11:7]] = 1'b1;
        rreg = w[11:7];
        pcm  = pcm + 4;
      end else begin
        rreg = written[w[11:7]] ? w[11:7] : 5'd0;
        pcm  = pcm + 4;
      end
    end
  endtask

  // Monitor: pops one expected item per running cycle and compares.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        dbg_addr = it.rreg;
        #1;
        chk("R2", "pc", pc, it.pc);
        chk("R5", "halt", {31'b0, halt}, {31'b0, it.halt});
        chk("R7", "illegal", {31'b0, ill}, {31'b0, it.ill});
        chk(it.rreg == 5'd0 ? "R4" : "R3", $sformatf("x%0d", it.rreg), dbg_data, it.rval);
      end
    end
  end

  task automatic reset_and_check();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset pc", pc, RV);
    chk("R1", "reset halt", {31'b0, halt}, 32'd0);
    chk("R1", "reset illegal", {31'b0, ill}, 32'd0);
  endtask

  task automatic release_and_drain();
    @(posedge clk);
    #1 rst = 1'b0;
    while (sb.size() != 0) @(posedge clk);
    #3;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 32'h0;
    written = 32'h1;
    for (int i = 0; i < PLEN; i++) prog[i] = enc_addi(0, 0, 0);

    // Run 1: arithmetic, immediate extremes, x0, unknown words, then halt
    prog[0]  = enc_addi(1, 0, 5);
    prog[1]  = enc_addi(2, 1, -3);
    prog[2]  = enc_addi(0, 1, 7);        // R4: discarded
    prog[3]  = enc_addi(3, 0, 2047);     // R3: largest immediate
    prog[4]  = enc_addi(4, 0, -2048);    // R3: most negative immediate
    prog[5]  = enc_addi(5, 4, -1);
    prog[6]  = enc_addi(2, 1, 1) | 32'h0000_2000; // R7: funct3 010, x2 must keep 2
    prog[7]  = 32'hFFFF_FFFF;            // R7
    prog[8]  = enc_addi(31, 3, 1);
    prog[9]  = enc_addi(6, 0, 0);
    prog[10] = BRK;                      // R5
    reset_and_check();
    build_trace(14);
    release_and_drain();

    // R6: a different word arrives while halted; nothing may move
    ovr_word = enc_addi(1, 0, 99);
    ovr_en   = 1'b1;
    repeat (3) @(negedge clk);
    dbg_addr = 5'd1;
    #1;
    chk("R6", "frozen pc", pc, RV + 32'd40);
    chk("R6", "halt sticky", {31'b0, halt}, 32'd1);
    chk("R6", "x1 frozen", dbg_data, 32'd5);
    chk("R6", "no illegal while halted", {31'b0, ill}, 32'd0);
    dbg_addr = 5'd0;
    #1;
    chk("R8", "x0 via inspection port", dbg_data, 32'd0);
    ovr_en = 1'b0;

    // Run 2 (R9): restart after halt, registers kept
    for (int i = 0; i < PLEN; i++) prog[i] = enc_addi(0, 0, 0);
    prog[0] = enc_addi(7, 31, 1);
    prog[1] = enc_addi(8, 5, 1);
    prog[2] = BRK;
    reset_and_check();
    build_trace(5);
    release_and_drain();
    dbg_addr = 5'd7;
    #1;
    chk("R9", "x7 after restart", dbg_data, 32'd2049);
    chk("R9", "halt again", {31'b0, halt}, 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule